// File: doc/BRIEF.md
# Run-time configurable timer/counter with compare channels

The block keeps a single counter whose wrap point can be set at run time to 8, 16, 24 or 32 bits. In timer mode it advances on ticks from a power-of-two clock divider, and only while it has been started. In counter mode it advances once for each count-task pulse, and the divider, start and stop have no effect on it. A small register port sets the mode, the width, the divider exponent, the per-channel shortcut bits and the compare values. The same port reads all of them back.

Each compare channel raises its own one-cycle event when the counter steps onto that channel's value. The value is masked to the active width before the comparison. A shortcut bit per channel turns a match into a clear of the counter, so the count repeats with a fixed period. A per-channel capture task copies the live count into that channel's register. Software can then read the count, or use it as a new compare point.

Top module: `cfg_timer`

## Requirements
- R1: After reset the counter reads 0, no event is high, the timer is stopped and every configuration register reads 0.
- R2: In timer mode, while running, the counter advances once every 2^P clock cycles, where P is the 4-bit divider field. Values of P above 9 behave as 9. After a start pulse the first advance happens 2^P cycles after the start takes effect.
- R3: The width field (bits 1:0) selects 8, 16, 24 or 32 bits for codes 0, 1, 2 and 3. After the all-ones value of the selected width, the next advance gives 0.
- R4: In counter mode (mode bit 0 = 1), each clock cycle with the count task high advances the counter by one. Without a count pulse the counter holds, whatever the start, stop and divider settings.
- R5: In timer mode, a start pulse enables counting and a stop pulse disables it. An advance that is due on the edge that takes the stop still happens. A stopped timer holds its value.
- R6: A clear pulse sets the counter and the divider phase to 0 on the next edge. Clear wins over an advance in the same cycle.
- R7: Channel i's event is high for exactly one cycle. That cycle is the first one in which the counter shows, after an advance, a value equal to that channel's compare value.
- R8: Compare values are masked to the selected width before comparison. Bits above the width are ignored.
- R9: When channel i's event is high and shortcut bit i (register 3) is set, the counter reads 0 in the next cycle.
- R10: Capture task i copies the current count into compare register i and leaves the counter unchanged. If a register write to that channel occurs in the same cycle, the capture wins.
- R11: Register addresses are: 0 mode, 1 width, 2 divider, 3 shortcuts, 8+i compare value i. Each written value reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_start | input | 1 | Start pulse for timer mode |
| task_stop | input | 1 | Stop pulse for timer mode |
| task_clear | input | 1 | Zero the counter and the divider phase |
| task_count | input | 1 | Count pulse for counter mode |
| task_capture | input | NCH | Per-channel capture pulse |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| cnt_o | output | 32 | Current count, masked to the width |
| evt_o | output | NCH | Per-channel compare event |

## Verification
On every cycle, the assertions check the following:
- a clear leaves a zero count;
- a stopped timer, or counter mode with no count pulse, holds its value;
- a full-width counter that advances wraps to zero;
- a raised event always coincides with the count equal to its masked compare value;
- a shortcut match is followed by a zero count.

Only the bench scenarios can show the following:
- the exact divider period, including the clamp at exponent 9;
- the one-cycle extra advance on stop;
- the wrap point for each width code;
- that high compare bits are ignored;
- that a capture beats a simultaneous write.

// File: rtl/cfg_timer.sv
`timescale 1ns/1ps
module cfg_timer #(
  parameter int NCH   = 4,
  parameter int PSMAX = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             task_start,
  input  logic             task_stop,
  input  logic             task_clear,
  input  logic             task_count,
  input  logic [NCH-1:0]   task_capture,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic [31:0]      cnt_o,
  output logic [NCH-1:0]   evt_o
);
  localparam int CCBASE = 8;

  logic              mode_cnt;
  logic [1:0]        wsel;
  logic [3:0]        psc_cfg;
  logic [NCH-1:0]    shorts;
  logic [31:0]       cc [NCH];
  logic              running;
  logic [PSMAX-1:0]  phase;
  logic [31:0]       cnt;
  logic [NCH-1:0]    evt;

  logic [31:0]       mask;
  logic [3:0]        psc_eff;
  logic [PSMAX-1:0]  lim;
  logic              tick, adv, zap;
  logic [31:0]       nxt;

  assign mask    = {{8{wsel == 2'd3}}, {8{wsel >= 2'd2}}, {8{wsel >= 2'd1}}, 8'hFF};
  assign psc_eff = (psc_cfg > 4'(PSMAX)) ? 4'(PSMAX) : psc_cfg;
  assign lim     = PSMAX'((32'd1 << psc_eff) - 32'd1);
  assign tick    = !mode_cnt && running && (phase >= lim);
  assign adv     = mode_cnt ? task_count : tick;
  assign zap     = task_clear | (|(evt & shorts));
  assign nxt     = (cnt + 32'd1) & mask;

  assign cnt_o = cnt & mask;
  assign evt_o = evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_cnt <= 1'b0;
      wsel     <= 2'd0;
      psc_cfg  <= 4'd0;
      shorts   <= '0;
      running  <= 1'b0;
      phase    <= '0;
      cnt      <= '0;
      evt      <= '0;
      for (int i = 0; i < NCH; i++) cc[i] <= '0;
    end else begin
      if (task_stop)       running <= 1'b0;
      else if (task_start) running <= 1'b1;

      if (zap)                       phase <= '0;
      else if (!mode_cnt && running) phase <= tick ? '0 : phase + 1'b1;

      if (zap)      cnt <= '0;
      else if (adv) cnt <= nxt;

      for (int i = 0; i < NCH; i++)
        evt[i] <= !zap && adv && (nxt == (cc[i] & mask));

      if (cfg_we) begin
        case (cfg_addr)
          4'd0: mode_cnt <= cfg_wdata[0];
          4'd1: wsel     <= cfg_wdata[1:0];
          4'd2: psc_cfg  <= cfg_wdata[3:0];
          4'd3: shorts   <= cfg_wdata[NCH-1:0];
          default: ;
        endcase
      end
      for (int i = 0; i < NCH; i++) begin
        if (task_capture[i])
          cc[i] <= cnt & mask;
        else if (cfg_we && cfg_addr == 4'(CCBASE + i))
          cc[i] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      4'd0: cfg_rdata = {31'd0, mode_cnt};
      4'd1: cfg_rdata = {30'd0, wsel};
      4'd2: cfg_rdata = {28'd0, psc_cfg};
      4'd3: cfg_rdata = {{(32-NCH){1'b0}}, shorts};
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (cfg_addr == 4'(CCBASE + i)) cfg_rdata = cc[i];
  end

  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    task_clear |=> (cnt_o == 32'd0));

  a_r4_hold_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cnt && !task_count && !zap) |=> $stable(cnt));

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cnt && !running && !zap) |=> $stable(cnt));

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !zap && cnt_o == mask) |=> (cnt == 32'd0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r7_event_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o[g] && !$past(cfg_we) && !$past(task_capture[g])) |-> (cnt_o == (cc[g] & mask)));
    a_r9_shortcut_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o[g] && shorts[g]) |=> (cnt == 32'd0));
  end
endmodule

// File: tb/cfg_timer_bench.sv
`timescale 1ns/1ps
module cfg_timer_bench;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic task_start = 0, task_stop = 0, task_clear = 0, task_count = 0;
  logic [NCH-1:0] task_capture = '0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, cnt_o;
  logic [NCH-1:0] evt_o;

  always #2 clk = ~clk;

  cfg_timer #(.NCH(NCH), .PSMAX(9)) u_cfg_timer (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
    .task_clear(task_clear), .task_count(task_count), .task_capture(task_capture),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cnt_o(cnt_o), .evt_o(evt_o));

  typedef struct { string req; int kind; logic [31:0] exp; } item_t;
  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic expect_val(input string req, input int kind, input logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = cnt_o;
        1: act = {{(32-NCH){1'b0}}, evt_o};
        default: act = cfg_rdata;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; step(1); cfg_we = 0;
  endtask
  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    cfg_addr = a; expect_val(req, 2, exp); @(negedge clk); #1;
  endtask
  task automatic count(input int n);
    task_count = 1; step(n); task_count = 0;
  endtask
  task automatic pstart(); task_start = 1; step(1); task_start = 0; endtask
  task automatic pstop();  task_stop  = 1; step(1); task_stop  = 0; endtask
  task automatic pclear(); task_clear = 1; step(1); task_clear = 0; endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    expect_val("R1 count", 0, 0);
    expect_val("R1 events", 1, 0);
    rd("R1 cc0", 4'd8, 0);
    rd("R1 width", 4'd1, 0);

    wr(2, 5); wr(0, 1);
    count(3);           expect_val("R4 three pulses", 0, 3);
    step(5);            expect_val("R4 no pulse holds", 0, 3);
    pstart(); step(4);  expect_val("R4 start ignored", 0, 3);
    pstop();
    pclear();           expect_val("R6 clear", 0, 0);
    count(2);
    task_clear = 1; task_count = 1; step(1); task_clear = 0; task_count = 0;
    expect_val("R6 clear beats count", 0, 0);

    wr(1, 0);
    count(255);         expect_val("R3 8-bit top", 0, 255);
    count(1);           expect_val("R3 8-bit wrap", 0, 0);
    wr(1, 1); pclear();
    count(65535);       expect_val("R3 16-bit top", 0, 65535);
    count(1);           expect_val("R3 16-bit wrap", 0, 0);
    rd("R11 width readback", 4'd1, 1);

    wr(0, 0); wr(1, 3); wr(2, 0); pclear();
    pstart();           expect_val("R5 start edge", 0, 0);
    step(5);            expect_val("R2 divide by 1", 0, 5);
    pstop();            expect_val("R5 last advance on stop", 0, 6);
    step(3);            expect_val("R5 stopped holds", 0, 6);

    wr(2, 2); pclear(); pstart();
    step(3);            expect_val("R2 div4 before tick", 0, 0);
    step(1);            expect_val("R2 div4 first tick", 0, 1);
    step(8);            expect_val("R2 div4 later", 0, 3);
    pstop();
    wr(2, 12); pclear(); pstart();
    step(511);          expect_val("R2 clamp before tick", 0, 0);
    step(1);            expect_val("R2 clamp at 512", 0, 1);
    pstop();
    rd("R11 divider readback", 4'd2, 12);

    wr(0, 1); wr(1, 3); wr(8, 4); wr(9, 32'h105); pclear();
    count(3);           expect_val("R7 before match cnt", 0, 3);
                        expect_val("R7 before match evt", 1, 0);
    count(1);           expect_val("R7 match cnt", 0, 4);
                        expect_val("R7 match evt", 1, 1);
    step(1);            expect_val("R7 single cycle", 1, 0);
    wr(1, 0);
    count(1);           expect_val("R8 masked 8-bit match", 1, 2);
    wr(1, 1); pclear();
    count(5);           expect_val("R8 high bits kept at 16-bit", 1, 0);

    wr(3, 1); wr(1, 3); pclear();
    count(4);           expect_val("R9 event", 1, 1);
    step(1);            expect_val("R9 cleared", 0, 0);
    count(4);           expect_val("R9 periodic event", 1, 1);
    step(1);            expect_val("R9 cleared again", 0, 0);
    wr(3, 0);

    pclear(); count(7);
    task_capture = 4'b0100; step(1); task_capture = '0;
    expect_val("R10 count unchanged", 0, 7);
    rd("R10 captured", 4'd10, 7);
    count(2);
    cfg_we = 1; cfg_addr = 4'd10; cfg_wdata = 99; task_capture = 4'b0100;
    step(1); cfg_we = 0; task_capture = '0;
    rd("R10 capture beats write", 4'd10, 9);
    wr(11, 99);
    rd("R11 cc3 readback", 4'd11, 99);

    @(negedge clk); #1;
    done = 1;
    summary();
    $finish;
  end
endmodule